// File: doc/BRIEF.md
# J1850 Link Error Supervisor

This block watches over the error conditions of a byte-level J1850 link controller. A receive symbol decoder upstream hands it one classified symbol per strobe: start of frame, end of data, end of frame, break, data bit or invalid symbol, plus a flag saying whether the receiver currently sits on a byte boundary. The supervisor also sees the sensed bus level, an interframe idle indication, the transmitter's current phase (start of frame or end of data) and the level it means to drive, the outcome of the CRC check, and a CPU request to send a frame. It owns the transmit grant: a request is held until the bus is passive and idle, then a one-cycle start pulse is issued and the block tracks the frame until the transmitter reports completion or the block aborts it.

Errors are turned into interrupt codes held in a small priority queue. The highest-priority pending code is shown on the state-vector output, an interrupt line follows it, and a CPU read strobe removes the code currently shown so the next one appears. The J1850 policy is built in: a bad symbol while transmitting counts as lost arbitration with the invalid-symbol code queued behind it, a bus that cannot be pulled active during start of frame (short to ground) aborts the frame without retry, and a bus stuck active (short to battery) simply keeps any request waiting. The receiver side keeps a resynchronisation state: after a break it waits for idle and then start of frame; after other receive errors it waits for start of frame.

Top module: `j1850_err_supervisor`

## Requirements
- R1: Under reset and in the first cycle after it, the state vector reads 8'h00, irq is 0, tx_go, tx_abort, tx_busy and rx_accept are 0, and rx_wait_idle is 1.
- R2: A symbol with sym_kind 6 (invalid) while tx_busy is 0 makes the state vector read 8'h1C after the next clock edge.
- R3: A symbol with sym_kind 6 while tx_busy is 1 makes the state vector read 8'h14 after the next edge, and 8'h1C after that code is popped by a read.
- R4: An end of data (sym_kind 2) or end of frame (sym_kind 3) with sym_on_byte at 0 queues 8'h1C; with sym_on_byte at 1 it queues nothing, and an end of frame on a boundary ends a received frame (rx_accept drops).
- R5: While tx_busy is 1, tx_in_eod at 1 with bus_act at 1 queues 8'h1C and aborts the frame.
- R6: While tx_busy is 1, tx_in_sof and tx_drv at 1 with bus_act at 0 queues 8'h1C and aborts the frame; no new tx_go follows until a new tx_req.
- R7: A request (tx_req) is granted with a one-cycle tx_go only in the cycle after one in which bus_act is 0 and bus_idle is 1; while bus_act stays 1 no tx_go occurs.
- R8: A break (sym_kind 4) queues 8'h1C, aborts a frame in progress, and sets rx_wait_idle; the receiver then ignores start of frame (sym_kind 1) until bus_idle is seen, after which a start of frame sets rx_accept.
- R9: A vec_rd strobe removes the code shown, revealing the next; priority is 8'h14 above 8'h1C above 8'h18, and 8'h00 shows when nothing is pending. A code raised in the same cycle as its pop stays pending.
- R10: crc_strobe with crc_bad at 1 queues 8'h18 and drops rx_accept, so the receiver waits for the next start of frame.
- R11: irq is 1 exactly when the state vector is non-zero.
- R12: tx_abort is a one-cycle pulse, coincides with tx_busy falling, and occurs at most once per granted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | A decoded symbol is present this cycle |
| sym_kind | input | 3 | Symbol class: 1 SOF, 2 EOD, 3 EOF, 4 break, 5 data bit, 6 invalid |
| sym_on_byte | input | 1 | Receiver is on a byte boundary |
| bus_act | input | 1 | Sensed bus level is active |
| bus_idle | input | 1 | Bus has been passive for the idle time |
| tx_req | input | 1 | CPU request to send a frame |
| tx_done | input | 1 | Transmitter finished the current frame |
| tx_in_sof | input | 1 | Transmitter is in its start-of-frame phase |
| tx_in_eod | input | 1 | Transmitter is in its end-of-data phase |
| tx_drv | input | 1 | Transmitter intends to drive the active level |
| crc_strobe | input | 1 | CRC check result is valid this cycle |
| crc_bad | input | 1 | CRC check failed |
| vec_rd | input | 1 | CPU read of the state vector (pops the shown code) |
| vec_code | output | 8 | Highest-priority pending interrupt code |
| irq | output | 1 | Interrupt request |
| tx_go | output | 1 | One-cycle grant to start transmission |
| tx_abort | output | 1 | One-cycle abort of the frame in progress |
| tx_busy | output | 1 | A granted frame is in progress |
| rx_accept | output | 1 | Receiver is inside a frame and accepting data |
| rx_wait_idle | output | 1 | Receiver is waiting for bus idle |

## Verification
The hardest situation to reach is a symbol error landing while a granted frame is in progress, with other codes already queued and a CPU read in the same cycle: it needs a request granted on a passive idle bus, then the error, then reads interleaved with fresh errors. Directed sequences first build each of these states explicitly (lost arbitration over a pending CRC code, the ground short in start of frame, the break with its idle-then-SOF recovery), and a long stretch of seeded random stimulus with weighted symbol, phase and read probabilities then keeps a bench-side queue model in step to cover same-cycle pop and raise collisions.

// File: rtl/j1850_err_pkg.sv
// Shared definitions for the J1850 link error supervisor.
// Assumes: queue slot index is also priority order, index 0 highest.
package j1850_err_pkg;

    localparam int SYM_W  = 3;
    localparam int VEC_W  = 8;
    localparam int NSLOT  = 3;

    // Symbol classes delivered by the receive decoder
    typedef enum logic [SYM_W-1:0] {
        SYM_NONE = 3'd0,
        SYM_SOF  = 3'd1,
        SYM_EOD  = 3'd2,
        SYM_EOF  = 3'd3,
        SYM_BRK  = 3'd4,
        SYM_BIT  = 3'd5,
        SYM_INV  = 3'd6
    } sym_e;

    // Queue slots in priority order
    localparam int SL_LOA = 0;
    localparam int SL_INV = 1;
    localparam int SL_CRC = 2;

    localparam logic [VEC_W-1:0] CODE_LOA  = 8'h14;
    localparam logic [VEC_W-1:0] CODE_INV  = 8'h1C;
    localparam logic [VEC_W-1:0] CODE_CRC  = 8'h18;
    localparam logic [VEC_W-1:0] CODE_NONE = 8'h00;

    // Interrupt code carried by a queue slot
    function automatic logic [VEC_W-1:0] slot_code(input int idx);
        case (idx)
            SL_LOA:  return CODE_LOA;
            SL_INV:  return CODE_INV;
            SL_CRC:  return CODE_CRC;
            default: return CODE_NONE;
        endcase
    endfunction

    typedef enum logic [1:0] {
        TG_IDLE = 2'd0,
        TG_PEND = 2'd1,
        TG_SEND = 2'd2
    } tx_st_e;

    typedef enum logic [1:0] {
        RX_HUNT_IDLE = 2'd0,
        RX_HUNT_SOF  = 2'd1,
        RX_FRAME     = 2'd2
    } rx_st_e;

endpackage

// File: rtl/j1850_err_classify.sv
// Combinational error classifier.
// Turns one cycle of symbol, bus and transmit-phase inputs into queue
// raise requests, an abort request and receive resync events.
// Assumes: the decoder presents at most one symbol per cycle and the
// sensed bus level is already filtered against propagation delay.
module j1850_err_classify
    import j1850_err_pkg::*;
#(
    parameter int SYMW  = SYM_W,
    parameter int SLOTS = NSLOT
) (
    input  logic            sym_valid,
    input  logic [SYMW-1:0] sym_kind,
    input  logic            sym_on_byte,
    input  logic            sending,
    input  logic            tx_in_sof,
    input  logic            tx_in_eod,
    input  logic            tx_drv,
    input  logic            bus_act,
    input  logic            crc_strobe,
    input  logic            crc_bad,
    output logic [SLOTS-1:0] raise,
    output logic            abort_req,
    output logic            rx_brk,
    output logic            rx_err,
    output logic            rx_sof,
    output logic            rx_eof_end
);

    logic inv_sym;
    logic frame_err;
    logic eod_clash;
    logic gnd_short;
    logic crc_fail;

    // Decode symbol-level error events for this cycle
    always_comb begin
        inv_sym   = sym_valid && (sym_kind == SYMW'(SYM_INV));
        frame_err = sym_valid && !sym_on_byte &&
                    ((sym_kind == SYMW'(SYM_EOD)) || (sym_kind == SYMW'(SYM_EOF)));
        rx_brk    = sym_valid && (sym_kind == SYMW'(SYM_BRK));
        rx_sof    = sym_valid && (sym_kind == SYMW'(SYM_SOF));
        rx_eof_end = sym_valid && sym_on_byte && (sym_kind == SYMW'(SYM_EOF));
        eod_clash = sending && tx_in_eod && bus_act;
        gnd_short = sending && tx_in_sof && tx_drv && !bus_act;
        crc_fail  = crc_strobe && crc_bad;
    end

    // Map events onto queue slots and the transmit abort
    always_comb begin
        raise         = '0;
        raise[SL_LOA] = inv_sym && sending;
        raise[SL_INV] = inv_sym || frame_err || rx_brk || eod_clash || gnd_short;
        raise[SL_CRC] = crc_fail;
        abort_req     = sending && (inv_sym || frame_err || rx_brk || eod_clash || gnd_short);
        rx_err        = inv_sym || frame_err || crc_fail;
    end

endmodule

// File: rtl/j1850_err_vecq.sv
// Priority queue of pending interrupt codes (the state vector).
// One sticky flag per slot; the lowest-index set flag is presented.
// A pop clears the presented flag; a raise in the same cycle wins.
module j1850_err_vecq
    import j1850_err_pkg::*;
#(
    parameter int SLOTS = NSLOT,
    parameter int VW    = VEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] raise,
    input  logic             pop,
    output logic [VW-1:0]    code,
    output logic             any
);

    logic [SLOTS-1:0] pend_q;
    logic [SLOTS-1:0] sel;

    // Pick the highest-priority pending slot and its code
    always_comb begin
        sel  = '0;
        code = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                sel     = '0;
                sel[i]  = 1'b1;
                code    = VW'(slot_code(i));
            end
        end
    end

    // Interrupt whenever any slot is pending
    always_comb any = |pend_q;

    // One sticky flag per slot
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_q[g] <= 1'b0;
            else
                pend_q[g] <= (pend_q[g] && !(pop && sel[g])) || raise[g];
        end
    end

endmodule

// File: rtl/j1850_tx_guard.sv
// Transmit grant and abort control.
// Holds a CPU request until the bus is passive and idle, grants it with
// a one-cycle start pulse, and ends the frame on completion or abort.
// Assumes: an aborted request is dropped; the CPU must ask again.
module j1850_tx_guard
    import j1850_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_req,
    input  logic tx_done,
    input  logic bus_act,
    input  logic bus_idle,
    input  logic abort_req,
    output logic sending,
    output logic tx_go,
    output logic tx_abort
);

    tx_st_e st_q;
    tx_st_e st_d;
    logic   go_d;
    logic   abort_d;

    // Next-state and pulse decisions
    always_comb begin
        st_d    = st_q;
        go_d    = 1'b0;
        abort_d = 1'b0;
        case (st_q)
            TG_IDLE: if (tx_req) st_d = TG_PEND;
            TG_PEND: begin
                if (!bus_act && bus_idle) begin
                    st_d = TG_SEND;
                    go_d = 1'b1;
                end
            end
            TG_SEND: begin
                if (abort_req) begin
                    st_d    = TG_IDLE;
                    abort_d = 1'b1;
                end else if (tx_done) begin
                    st_d = TG_IDLE;
                end
            end
            default: st_d = TG_IDLE;
        endcase
    end

    // State and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= TG_IDLE;
            tx_go    <= 1'b0;
            tx_abort <= 1'b0;
        end else begin
            st_q     <= st_d;
            tx_go    <= go_d;
            tx_abort <= abort_d;
        end
    end

    // Frame in progress
    always_comb sending = (st_q == TG_SEND);

endmodule

// File: rtl/j1850_rx_sync.sv
// Receive resynchronisation state.
// After reset or a break it waits for bus idle, then for start of
// frame; other receive errors send it back to waiting for start of frame.
module j1850_rx_sync
    import j1850_err_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic rx_brk,
    input  logic rx_err,
    input  logic rx_sof,
    input  logic rx_eof_end,
    output logic rx_accept,
    output logic rx_wait_idle
);

    rx_st_e st_q;
    rx_st_e st_d;

    // Next receive state; a break overrides everything
    always_comb begin
        st_d = st_q;
        if (rx_brk) begin
            st_d = RX_HUNT_IDLE;
        end else begin
            case (st_q)
                RX_HUNT_IDLE: if (bus_idle) st_d = RX_HUNT_SOF;
                RX_HUNT_SOF:  if (rx_sof) st_d = RX_FRAME;
                RX_FRAME:     if (rx_err || rx_eof_end) st_d = RX_HUNT_SOF;
                default:      st_d = RX_HUNT_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_HUNT_IDLE;
        else        st_q <= st_d;
    end

    // Decoded status
    always_comb begin
        rx_accept    = (st_q == RX_FRAME);
        rx_wait_idle = (st_q == RX_HUNT_IDLE);
    end

endmodule

// File: rtl/j1850_err_supervisor.sv
// Top of the J1850 link error supervisor.
// Joins the classifier, the code queue, the transmit guard and the
// receive resync state. All outputs are registered or decoded from
// registers, so each input's effect is visible after the next edge.
module j1850_err_supervisor
    import j1850_err_pkg::*;
#(
    parameter int SYMW = SYM_W,
    parameter int VW   = VEC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sym_valid,
    input  logic [SYMW-1:0] sym_kind,
    input  logic            sym_on_byte,
    input  logic            bus_act,
    input  logic            bus_idle,
    input  logic            tx_req,
    input  logic            tx_done,
    input  logic            tx_in_sof,
    input  logic            tx_in_eod,
    input  logic            tx_drv,
    input  logic            crc_strobe,
    input  logic            crc_bad,
    input  logic            vec_rd,
    output logic [VW-1:0]   vec_code,
    output logic            irq,
    output logic            tx_go,
    output logic            tx_abort,
    output logic            tx_busy,
    output logic            rx_accept,
    output logic            rx_wait_idle
);

    localparam int SLOTS = NSLOT;

    logic [SLOTS-1:0] raise;
    logic             abort_req;
    logic             rx_brk;
    logic             rx_err;
    logic             rx_sof;
    logic             rx_eof_end;
    logic             sending;

    j1850_err_classify #(.SYMW(SYMW), .SLOTS(SLOTS)) i_classify (
        .sym_valid  (sym_valid),
        .sym_kind   (sym_kind),
        .sym_on_byte(sym_on_byte),
        .sending    (sending),
        .tx_in_sof  (tx_in_sof),
        .tx_in_eod  (tx_in_eod),
        .tx_drv     (tx_drv),
        .bus_act    (bus_act),
        .crc_strobe (crc_strobe),
        .crc_bad    (crc_bad),
        .raise      (raise),
        .abort_req  (abort_req),
        .rx_brk     (rx_brk),
        .rx_err     (rx_err),
        .rx_sof     (rx_sof),
        .rx_eof_end (rx_eof_end)
    );

    j1850_err_vecq #(.SLOTS(SLOTS), .VW(VW)) i_vecq (
        .clk  (clk),
        .rst_n(rst_n),
        .raise(raise),
        .pop  (vec_rd),
        .code (vec_code),
        .any  (irq)
    );

    j1850_tx_guard i_tx_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_req   (tx_req),
        .tx_done  (tx_done),
        .bus_act  (bus_act),
        .bus_idle (bus_idle),
        .abort_req(abort_req),
        .sending  (sending),
        .tx_go    (tx_go),
        .tx_abort (tx_abort)
    );

    j1850_rx_sync i_rx_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_idle    (bus_idle),
        .rx_brk      (rx_brk),
        .rx_err      (rx_err),
        .rx_sof      (rx_sof),
        .rx_eof_end  (rx_eof_end),
        .rx_accept   (rx_accept),
        .rx_wait_idle(rx_wait_idle)
    );

    // Frame-in-progress status
    always_comb tx_busy = sending;

endmodule

// File: rtl/j1850_err_chk.sv
// Assertion checker for the J1850 link error supervisor, bound to the top.
module j1850_err_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sym_valid,
    input logic [2:0] sym_kind,
    input logic       bus_act,
    input logic       bus_idle,
    input logic [7:0] vec_code,
    input logic       irq,
    input logic       tx_go,
    input logic       tx_abort,
    input logic       tx_busy,
    input logic       rx_wait_idle
);

    a_r11_irq_tracks_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (vec_code != 8'h00));

    a_r2_invalid_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 3'd6) |=> irq);

    a_r3_loa_presented_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 3'd6 && tx_busy) |=> (vec_code == 8'h14));

    a_r12_abort_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    a_r12_abort_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> !tx_busy);

    a_r7_grant_needs_passive: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> $past(!bus_act && bus_idle));

    a_r8_break_waits_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_kind == 3'd4) |=> rx_wait_idle);

endmodule

bind j1850_err_supervisor j1850_err_chk i_chk (.*);

// File: tb/test_j1850_err_supervisor.sv
`timescale 1ns/1ps
module test_j1850_err_supervisor;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sym_valid, sym_on_byte, bus_act, bus_idle;
    logic [2:0] sym_kind;
    logic       tx_req, tx_done, tx_in_sof, tx_in_eod, tx_drv;
    logic       crc_strobe, crc_bad, vec_rd;
    logic [7:0] vec_code;
    logic       irq, tx_go, tx_abort, tx_busy, rx_accept, rx_wait_idle;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Bench model state
    bit m_loa, m_inv, m_crc;
    int m_tx;   // 0 idle, 1 pending, 2 sending
    int m_rx;   // 0 wait idle, 1 wait SOF, 2 in frame
    bit m_go, m_abort;

    always #5 clk = ~clk;

    j1850_err_supervisor i_j1850_err_supervisor (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_kind(sym_kind),
        .sym_on_byte(sym_on_byte), .bus_act(bus_act), .bus_idle(bus_idle),
        .tx_req(tx_req), .tx_done(tx_done), .tx_in_sof(tx_in_sof),
        .tx_in_eod(tx_in_eod), .tx_drv(tx_drv), .crc_strobe(crc_strobe),
        .crc_bad(crc_bad), .vec_rd(vec_rd), .vec_code(vec_code), .irq(irq),
        .tx_go(tx_go), .tx_abort(tx_abort), .tx_busy(tx_busy),
        .rx_accept(rx_accept), .rx_wait_idle(rx_wait_idle)
    );

    function automatic int exp_code(bit loa, bit inv, bit crc);
        if (loa) return 8'h14;
        if (inv) return 8'h1C;
        if (crc) return 8'h18;
        return 8'h00;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        sym_valid = 0; sym_kind = 0; sym_on_byte = 1;
        bus_act = 0; bus_idle = 0; tx_req = 0; tx_done = 0;
        tx_in_sof = 0; tx_in_eod = 0; tx_drv = 0;
        crc_strobe = 0; crc_bad = 0; vec_rd = 0;
    endtask

    task automatic model_reset();
        m_loa = 0; m_inv = 0; m_crc = 0; m_tx = 0; m_rx = 0; m_go = 0; m_abort = 0;
    endtask

    // Advance the model by one edge from the present inputs, then compare
    task automatic tick();
        bit send, inv_ev, fram, brk, clash, gshort, r_inv, r_loa, r_crc, rxe;
        bit n_loa, n_inv, n_crc;
        int pres, n_tx, n_rx;
        send   = (m_tx == 2);
        inv_ev = sym_valid && sym_kind == 6;
        fram   = sym_valid && !sym_on_byte && (sym_kind == 2 || sym_kind == 3);
        brk    = sym_valid && sym_kind == 4;
        clash  = send && tx_in_eod && bus_act;
        gshort = send && tx_in_sof && tx_drv && !bus_act;
        r_inv  = inv_ev || fram || brk || clash || gshort;
        r_loa  = inv_ev && send;
        r_crc  = crc_strobe && crc_bad;
        rxe    = inv_ev || fram || r_crc;
        pres   = exp_code(m_loa, m_inv, m_crc);
        n_loa  = (m_loa && !(vec_rd && pres == 8'h14)) || r_loa;
        n_inv  = (m_inv && !(vec_rd && pres == 8'h1C)) || r_inv;
        n_crc  = (m_crc && !(vec_rd && pres == 8'h18)) || r_crc;
        n_tx = m_tx; m_go = 0; m_abort = 0;
        if (m_tx == 0 && tx_req) n_tx = 1;
        else if (m_tx == 1 && !bus_act && bus_idle) begin n_tx = 2; m_go = 1; end
        else if (m_tx == 2) begin
            if (r_inv) begin n_tx = 0; m_abort = 1; end
            else if (tx_done) n_tx = 0;
        end
        n_rx = m_rx;
        if (brk) n_rx = 0;
        else if (m_rx == 0 && bus_idle) n_rx = 1;
        else if (m_rx == 1 && sym_valid && sym_kind == 1) n_rx = 2;
        else if (m_rx == 2 && (rxe || (sym_valid && sym_on_byte && sym_kind == 3))) n_rx = 1;
        @(posedge clk);
        #1;
        m_loa = n_loa; m_inv = n_inv; m_crc = n_crc; m_tx = n_tx; m_rx = n_rx;
        check("R9 model vec_code", vec_code, exp_code(m_loa, m_inv, m_crc));
        check("R11 model irq", irq, (m_loa || m_inv || m_crc));
        check("R7 model tx_go", tx_go, m_go);
        check("R12 model tx_abort", tx_abort, m_abort);
        check("R6 model tx_busy", tx_busy, m_tx == 2);
        check("R8 model rx_accept", rx_accept, m_rx == 2);
        check("R8 model rx_wait_idle", rx_wait_idle, m_rx == 0);
        clear_inputs();
    endtask

    task automatic sym(int k, bit onb);
        sym_valid = 1; sym_kind = 3'(k); sym_on_byte = onb;
    endtask

    task automatic start_frame();
        bus_idle = 1; tx_req = 1; tick();
        bus_idle = 1; tick();
        check("R7 grant pulse", tx_go, 1);
        check("R7 busy after grant", tx_busy, 1);
    endtask

    task automatic drain();
        for (int i = 0; i < 4; i++) begin vec_rd = 1; tick(); end
    endtask

    task automatic rx_enter_frame();
        bus_idle = 1; tick();
        sym(1, 1); tick();
    endtask

    initial begin
        void'($urandom(32'd1850));
        clear_inputs();
        model_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset vec", vec_code, 0);
        check("R1 reset irq", irq, 0);
        check("R1 reset wait_idle", rx_wait_idle, 1);
        check("R1 reset busy", tx_busy, 0);
        check("R1 reset go/abort/accept", {tx_go, tx_abort, rx_accept}, 0);
        rst_n = 1;
        tick();
        check("R1 after reset vec", vec_code, 0);

        // R2 and R9: invalid while receiving, then pop
        sym(6, 1); tick();
        check("R2 invalid idle", vec_code, 8'h1C);
        check("R11 irq set", irq, 1);
        vec_rd = 1; tick();
        check("R9 pop empties", vec_code, 8'h00);
        check("R11 irq clear", irq, 0);

        // R7: bus stuck active holds the request
        bus_act = 1; tx_req = 1; tick();
        for (int i = 0; i < 20; i++) begin
            bus_act = 1; tick();
            check("R7 no grant while active", tx_go, 0);
        end
        bus_act = 0; bus_idle = 1; tick();
        check("R7 grant after passive", tx_go, 1);
        tick();
        check("R7 grant one cycle", tx_go, 0);

        // R3 and R12: invalid while sending
        sym(6, 1); tick();
        check("R3 LOA first", vec_code, 8'h14);
        check("R12 abort pulse", tx_abort, 1);
        check("R12 busy drops", tx_busy, 0);
        tick();
        check("R12 abort one cycle", tx_abort, 0);
        vec_rd = 1; tick();
        check("R3 invalid behind LOA", vec_code, 8'h1C);
        vec_rd = 1; tick();
        check("R9 drained", vec_code, 8'h00);

        // R6: ground short in SOF, no retry
        start_frame();
        tx_in_sof = 1; tx_drv = 1; bus_act = 0; tick();
        check("R6 short code", vec_code, 8'h1C);
        check("R6 abort", tx_abort, 1);
        for (int i = 0; i < 10; i++) begin
            bus_idle = 1; tick();
            check("R6 no retry", tx_go, 0);
        end
        drain();

        // R5: active symbol sensed during own EOD
        start_frame();
        tx_in_eod = 1; bus_act = 1; tick();
        check("R5 EOD clash code", vec_code, 8'h1C);
        check("R5 EOD clash abort", tx_abort, 1);
        drain();

        // R4: boundary handling on receive
        rx_enter_frame();
        check("R4 in frame", rx_accept, 1);
        sym(2, 1); tick();
        check("R4 EOD on boundary no code", vec_code, 8'h00);
        sym(3, 0); tick();
        check("R4 EOF off boundary", vec_code, 8'h1C);
        check("R4 frame dropped", rx_accept, 0);
        drain();
        sym(1, 1); tick();
        sym(3, 1); tick();
        check("R4 EOF on boundary ends frame", rx_accept, 0);
        check("R4 EOF on boundary no code", vec_code, 8'h00);

        // R8: break, wait idle, then SOF
        sym(1, 1); tick();
        sym(4, 1); tick();
        check("R8 break code", vec_code, 8'h1C);
        check("R8 wait idle", rx_wait_idle, 1);
        sym(1, 1); tick();
        check("R8 SOF ignored before idle", rx_accept, 0);
        bus_idle = 1; tick();
        sym(1, 1); tick();
        check("R8 SOF after idle", rx_accept, 1);
        drain();

        // R10 and R9 priority
        crc_strobe = 1; crc_bad = 1; tick();
        check("R10 CRC code", vec_code, 8'h18);
        check("R10 receiver drops frame", rx_accept, 0);
        sym(6, 1); tick();
        check("R9 invalid above CRC", vec_code, 8'h1C);
        vec_rd = 1; sym(6, 1); tick();
        check("R9 raise beats pop", vec_code, 8'h1C);
        vec_rd = 1; tick();
        check("R9 CRC revealed", vec_code, 8'h18);
        vec_rd = 1; tick();
        check("R9 empty", vec_code, 8'h00);

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            sym_valid   = ($urandom_range(99) < 30);
            sym_kind    = 3'($urandom_range(6, 1));
            sym_on_byte = ($urandom_range(99) < 80);
            bus_act     = ($urandom_range(99) < 30);
            bus_idle    = !bus_act && ($urandom_range(99) < 50);
            tx_req      = ($urandom_range(99) < 10);
            tx_done     = ($urandom_range(99) < 5);
            tx_in_sof   = ($urandom_range(99) < 10);
            tx_in_eod   = ($urandom_range(99) < 10);
            tx_drv      = ($urandom_range(99) < 50);
            crc_strobe  = ($urandom_range(99) < 5);
            crc_bad     = ($urandom_range(99) < 50);
            vec_rd      = ($urandom_range(99) < 30);
            tick();
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule